// File: doc/BRIEF.md
# Cooperative Thread Context Arbiter

This block decides which of eight hardware threads owns the pipeline of a multithreaded processing engine. Each thread is always in one of four scheduling states: inactive, ready, sleeping or executing. Only a thread enabled by the configuration input can take part in scheduling, and at most one thread executes at a time. The executing thread keeps the pipeline until it asks to sleep. There is no preemption.

A sleep request carries a wait mask over the thread's fifteen event signals. Event pulses from I/O units or other threads are latched per thread at any time, including before the thread goes to sleep. A sleeping thread returns to ready once every event in its wait mask has been latched. The events it used are then cleared, and the others stay latched. When the pipeline is free, the next owner is taken from the ready threads in round-robin order, starting from the thread after the one that last went to sleep. Each swap leaves one idle cycle. The block supplies the thread index, a valid flag and the per-thread states. Fetch, register files and program counters belong to the surrounding engine.

Top module: `ctx_arbiter`

## Requirements
- R1: While reset is asserted, every thread reads as inactive and `exec_valid_o` is low.
- R2: Thread t's state is reported on `thr_state_o[2t+1:2t]` with codes 00 inactive, 01 ready, 10 sleeping, 11 executing. An inactive thread whose enable bit is high becomes ready on the next clock edge.
- R3: A thread that is not executing and whose enable bit is low becomes inactive on the next edge. Any events latched for it are discarded.
- R4: At most one thread is in the executing state. `exec_valid_o` is high exactly when one thread executes, and `exec_idx_o` then names that thread.
- R5: The executing thread keeps the pipeline until `sleep_req_i` is sampled high. `sleep_req_i` has no effect while `exec_valid_o` is low.
- R6: When `sleep_req_i` is sampled high, the executing thread enters the sleeping state on that edge and `exec_valid_o` is low for the following cycle. If a thread was already ready, it is executing one edge later.
- R7: When the pipeline is free, the lowest-offset ready and enabled thread is chosen, counting upward with wrap from the thread after the last one to sleep. After reset the search starts at thread 0.
- R8: A sleeping thread is never chosen directly. It becomes ready on the edge after all bits of its wait mask (`evt_pulse_i[15t+14:15t]` for thread t) have been latched. An empty mask makes it ready on the edge after it went to sleep.
- R9: Events that arrive before a sleep request count toward the wait. On wake-up only the masked events are cleared, and unmasked latched events stay for a later wait.
- R10: If no thread is ready, `exec_valid_o` stays low. A thread that becomes ready is executing on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| thr_en_i | input | 8 | Per-thread enable configuration |
| sleep_req_i | input | 1 | Executing thread asks to sleep |
| sleep_mask_i | input | 15 | Events the sleeping thread waits on |
| evt_pulse_i | input | 120 | Event pulses, 15 per thread, thread t at bits 15t+14:15t |
| exec_idx_o | output | 3 | Index of the executing thread |
| exec_valid_o | output | 1 | A thread is executing |
| thr_state_o | output | 16 | Two-bit state per thread |

## Verification
The bench targets the pointer after a sleep. A design that searched from thread 0 would give a thread that woke early the pipeline ahead of its turn. It checks a wait that is only partly met and events latched before the sleep. A design that woke on any event, or lost early pulses, would wake too soon or never. It checks that a second wait needs fresh events, which a design that never clears consumed events would miss. It covers the state with every thread asleep, where a broken design would raise valid with a stale index. It also covers disabling a ready thread with latched events, which must not leave those events behind to wake it later.

// File: rtl/ctx_arb_pkg.sv
package ctx_arb_pkg;
  typedef enum logic [1:0] {
    TS_INACT = 2'b00,
    TS_READY = 2'b01,
    TS_SLEEP = 2'b10,
    TS_EXEC  = 2'b11
  } thr_state_e;
endpackage

// File: rtl/ctx_evt_track.sv
// Per-thread event latch and wait-mask comparison.
module ctx_evt_track #(
  parameter int NEVT = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [NEVT-1:0] evt_i,
  input  logic            arm_i,
  input  logic [NEVT-1:0] mask_i,
  input  logic            consume_i,
  output logic            met_o
);
  logic [NEVT-1:0] pend_q, pend_d;
  logic [NEVT-1:0] wmask_q;

  always_comb begin
    if (!en_i) begin
      pend_d = '0;
    end else if (consume_i) begin
      pend_d = (pend_q & ~wmask_q) | evt_i;
    end else begin
      pend_d = pend_q | evt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wmask_q <= '0;
    end else if (arm_i) begin
      wmask_q <= mask_i;
    end
  end

  assign met_o = ((wmask_q & ~pend_q) == '0);
endmodule

// File: rtl/ctx_rr_pick.sv
// Round-robin selection: first request at or after base, wrapping.
module ctx_rr_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] base_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] cand;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    cand    = '0;
    for (int i = 0; i < N; i++) begin
      cand = base_i + IW'(i);
      if (!found_o && req_i[cand]) begin
        found_o = 1'b1;
        idx_o   = cand;
      end
    end
  end
endmodule

// File: rtl/ctx_arbiter.sv
// Cooperative thread context arbiter. NTHR must be a power of two.
module ctx_arbiter #(
  parameter int NTHR = 8,
  parameter int NEVT = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NTHR-1:0]          thr_en_i,
  input  logic                     sleep_req_i,
  input  logic [NEVT-1:0]          sleep_mask_i,
  input  logic [NTHR*NEVT-1:0]     evt_pulse_i,
  output logic [$clog2(NTHR)-1:0]  exec_idx_o,
  output logic                     exec_valid_o,
  output logic [2*NTHR-1:0]        thr_state_o
);
  import ctx_arb_pkg::*;

  localparam int IW = $clog2(NTHR);

  thr_state_e    state_q [NTHR];
  thr_state_e    state_d [NTHR];
  logic [NTHR-1:0] is_exec, pick_req, met, consume, arm;
  logic          exec_any, pick_found, pick_go, sleep_go;
  logic [IW-1:0] pick_idx, ptr_q, ptr_d, idx_q, idx_d;

  assign exec_any = |is_exec;
  assign sleep_go = exec_any & sleep_req_i;
  assign pick_go  = ~exec_any & pick_found;

  ctx_rr_pick #(.N(NTHR), .IW(IW)) u_pick (
    .req_i   (pick_req),
    .base_i  (ptr_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign is_exec[t]  = (state_q[t] == TS_EXEC);
    assign pick_req[t] = (state_q[t] == TS_READY) & thr_en_i[t];
    assign arm[t]      = is_exec[t] & sleep_req_i;
    assign consume[t]  = (state_q[t] == TS_SLEEP) & thr_en_i[t] & met[t];
    assign thr_state_o[2*t +: 2] = state_q[t];

    ctx_evt_track #(.NEVT(NEVT)) u_evt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (thr_en_i[t]),
      .evt_i     (evt_pulse_i[t*NEVT +: NEVT]),
      .arm_i     (arm[t]),
      .mask_i    (sleep_mask_i),
      .consume_i (consume[t]),
      .met_o     (met[t])
    );

    always_comb begin
      state_d[t] = state_q[t];
      unique case (state_q[t])
        TS_INACT: if (thr_en_i[t]) state_d[t] = TS_READY;
        TS_READY: begin
          if (!thr_en_i[t]) state_d[t] = TS_INACT;
          else if (pick_go && pick_idx == IW'(t)) state_d[t] = TS_EXEC;
        end
        TS_EXEC:  if (sleep_req_i) state_d[t] = TS_SLEEP;
        TS_SLEEP: begin
          if (!thr_en_i[t]) state_d[t] = TS_INACT;
          else if (met[t]) state_d[t] = TS_READY;
        end
        default:  state_d[t] = TS_INACT;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[t] <= TS_INACT;
      end else begin
        state_q[t] <= state_d[t];
      end
    end
  end

  assign ptr_d = idx_q + IW'(1);
  assign idx_d = pick_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (sleep_go) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (pick_go) begin
      idx_q <= idx_d;
    end
  end

  assign exec_idx_o   = idx_q;
  assign exec_valid_o = exec_any;
endmodule

// File: rtl/ctx_arbiter_chk.sv
module ctx_arbiter_chk #(
  parameter int NTHR = 8,
  parameter int NEVT = 15
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NTHR-1:0]          thr_en_i,
  input logic                     sleep_req_i,
  input logic [NEVT-1:0]          sleep_mask_i,
  input logic [NTHR*NEVT-1:0]     evt_pulse_i,
  input logic [$clog2(NTHR)-1:0]  exec_idx_o,
  input logic                     exec_valid_o,
  input logic [2*NTHR-1:0]        thr_state_o
);
  logic [NTHR-1:0] ex;

  for (genvar t = 0; t < NTHR; t++) begin : g_c
    assign ex[t] = (thr_state_o[2*t +: 2] == 2'b11);

    assert_inact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_state_o[2*t +: 2] == 2'b00 && thr_en_i[t]) |=> thr_state_o[2*t +: 2] == 2'b01);

    assert_disable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!thr_en_i[t] && thr_state_o[2*t +: 2] != 2'b11) |=> thr_state_o[2*t +: 2] == 2'b00);

    assert_no_sleep_exec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_state_o[2*t +: 2] == 2'b10) |=> thr_state_o[2*t +: 2] != 2'b11);
  end

  assert_one_exec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ex));

  assert_valid_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o == (ex != '0));

  assert_idx_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> thr_state_o[2*exec_idx_o +: 2] == 2'b11);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && !sleep_req_i) |=> (exec_valid_o && $stable(exec_idx_o)));

  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && sleep_req_i) |=> !exec_valid_o);
endmodule

bind ctx_arbiter ctx_arbiter_chk #(.NTHR(NTHR), .NEVT(NEVT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .thr_en_i     (thr_en_i),
  .sleep_req_i  (sleep_req_i),
  .sleep_mask_i (sleep_mask_i),
  .evt_pulse_i  (evt_pulse_i),
  .exec_idx_o   (exec_idx_o),
  .exec_valid_o (exec_valid_o),
  .thr_state_o  (thr_state_o)
);

// File: tb/sim_ctx_arbiter.sv
`timescale 1ns/1ps
module sim_ctx_arbiter;
  localparam int NT = 8;
  localparam int NE = 15;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NT-1:0]     en;
  logic              slp;
  logic [NE-1:0]     msk;
  logic [NT*NE-1:0]  evt;
  logic [2:0]        idx;
  logic              vld;
  logic [2*NT-1:0]   st;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ctx_arbiter #(.NTHR(NT), .NEVT(NE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .thr_en_i(en), .sleep_req_i(slp),
    .sleep_mask_i(msk), .evt_pulse_i(evt), .exec_idx_o(idx),
    .exec_valid_o(vld), .thr_state_o(st)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sof(input int t);
    return int'(st[2*t +: 2]);
  endfunction

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [NT-1:0] e);
    rst_n = 1'b0; slp = 1'b0; msk = '0; evt = '0; en = e;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int t, input logic [NE-1:0] b);
    evt[t*NE +: NE] = b;
    step();
    evt = '0;
  endtask

  task automatic go_sleep(input logic [NE-1:0] m);
    slp = 1'b1; msk = m;
    step();
    slp = 1'b0; msk = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; slp = 1'b0; msk = '0; evt = '0; en = '1;
    step(2);
    chk("R1 states", int'(st), 0);
    chk("R1 valid", int'(vld), 0);
    rst_n = 1'b1;
    step();
    chk("R2 all ready", int'(st), 16'h5555);
    chk("R2 no exec yet", int'(vld), 0);
    step();
    chk("R7 first pick idx", int'(idx), 0);
    chk("R4 valid", int'(vld), 1);
    chk("R4 state exec", sof(0), 3);
  endtask

  task automatic t_rr;
    do_reset('1);
    step(2);
    for (int k = 0; k < NT; k++) begin
      chk("R7 rr order", int'(idx), k);
      chk("R7 rr valid", int'(vld), 1);
      go_sleep(15'h0001);
      chk("R6 idle cycle", int'(vld), 0);
      chk("R6 sleeping", sof(k), 2);
      if (k < NT - 1) step();
    end
    step(3);
    chk("R10 none ready", int'(vld), 0);
    pulse(3, 15'h0001);
    chk("R8 still asleep at latch", sof(3), 2);
    step();
    chk("R8 woke", sof(3), 1);
    chk("R10 still idle", int'(vld), 0);
    step();
    chk("R10 picked", int'(idx), 3);
    chk("R10 valid", int'(vld), 1);
  endtask

  task automatic t_pointer;
    do_reset('1);
    step(2);
    go_sleep(15'h0001);
    step();
    chk("R7 next after 0", int'(idx), 1);
    pulse(0, 15'h0001);
    step();
    chk("R8 thread0 ready", sof(0), 1);
    go_sleep(15'h0002);
    step();
    chk("R7 search after sleeper", int'(idx), 2);
  endtask

  task automatic t_hold;
    do_reset(8'h03);
    step(2);
    chk("R5 start", int'(idx), 0);
    step(4);
    chk("R5 held idx", int'(idx), 0);
    chk("R5 held valid", int'(vld), 1);
    chk("R5 other ready", sof(1), 1);
  endtask

  task automatic t_ignore;
    do_reset(8'h01);
    slp = 1'b1;
    step();
    chk("R5 ready with sleep high", sof(0), 1);
    step();
    slp = 1'b0;
    chk("R5 sleep ignored when idle", sof(0), 3);
    step();
    chk("R5 still executing", int'(vld), 1);
  endtask

  task automatic t_empty_mask;
    do_reset(8'h01);
    step(2);
    go_sleep('0);
    chk("R8 empty mask sleeping", sof(0), 2);
    step();
    chk("R8 empty mask ready", sof(0), 1);
    chk("R8 empty mask idle", int'(vld), 0);
    step();
    chk("R8 empty mask reruns", int'(vld), 1);
  endtask

  task automatic t_events;
    do_reset(8'h01);
    step(2);
    pulse(0, 15'h0020);
    go_sleep(15'h0060);
    step();
    chk("R8 partial wait", sof(0), 2);
    pulse(0, 15'h0200);
    chk("R8 unrelated event", sof(0), 2);
    pulse(0, 15'h0040);
    chk("R8 last event latching", sof(0), 2);
    step();
    chk("R9 early event counted", sof(0), 1);
    step();
    chk("R9 exec again", int'(vld), 1);
    go_sleep(15'h0200);
    step();
    chk("R9 kept unmasked event", sof(0), 1);
    step();
    go_sleep(15'h0020);
    step(3);
    chk("R9 consumed event cleared", sof(0), 2);
  endtask

  task automatic t_disable;
    do_reset(8'h03);
    step(2);
    pulse(1, 15'h0004);
    en = 8'h01;
    step();
    chk("R3 disabled inactive", sof(1), 0);
    chk("R3 exec kept", int'(idx), 0);
    en = 8'h03;
    step();
    chk("R2 re-enabled ready", sof(1), 1);
    go_sleep(15'h0001);
    step();
    chk("R6 swap to 1", int'(idx), 1);
    go_sleep(15'h0004);
    step(3);
    chk("R3 events discarded", sof(1), 2);
    chk("R3 no exec", int'(vld), 0);
  endtask

  initial begin
    t_reset();
    t_rr();
    t_pointer();
    t_hold();
    t_ignore();
    t_empty_mask();
    t_events();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule